// File: doc/BRIEF.md
# Indexed Register Port with Interrupt Flags

This block is the host side of a small real-time-clock register file. A host reaches 128 byte-wide locations through only two addresses: a write to the even address selects a location by loading a 7-bit index, and reads or writes at the odd address then act on the selected byte. Four locations hold the control bytes: A (rate and divider settings plus a read-only update-in-progress bit), B (enables and modes), C (interrupt flags) and D (a fixed status byte). All other locations are plain storage.

The calendar and periodic-rate blocks sit beside this one and send single-cycle event pulses. Each pulse sets its flag in C together with a summary bit, and the summary bit drives the interrupt request. A host read of C returns the flags and clears them in the same access. The current A and B bytes are brought out so that the neighbouring blocks can decode rates and enables. A separate reset-event input quiets the enables and flags without disturbing the stored time or rate settings.

Top module: `rtc_regport`

## Requirements
- R1: A write at even address (busAddr=0) stores busWdata bits 6:0 as the index; bit 7 is dropped. A read at the even address returns 0xFF.
- R2: After rstN is released A reads 0x26, B reads 0x02, C reads 0x00, D reads 0x80, and irq is low.
- R3: A write to A (index 10) stores data bits 6:0 and keeps the current value of A bit 7 (update-in-progress).
- R4: A write to B (index 11) stores the byte as given, except that when data bit 7 (SET) is 1 the stored bit 4 (update-ended enable) is forced to 0 and A bit 7 is cleared.
- R5: Writes to C (index 12) and D (index 13) have no effect.
- R6: An evPeriodic, evAlarm or evUpdate pulse sets C bit 6, 5 or 4 respectively together with C bit 7; irq equals C bit 7 and rises in the cycle after the pulse.
- R7: A read of C returns its current value, after which C is 0x00 and irq is low.
- R8: An event pulse in the same cycle as a read of C is not lost: its flag and bit 7 are set in C afterwards.
- R9: A resetEvt pulse clears B bits 6, 5 and 3, clears C bits 7 to 4, and lowers irq; other bits of A and B are kept. It overrides events of the same cycle.
- R10: Indices 0 to 9 and 14 to 127 are plain storage that return the last byte written.
- R11: A uipSet pulse sets A bit 7 only while B bit 7 (SET) is 0; a uipClr pulse clears A bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Host write strobe, one cycle per access |
| busRd | input | 1 | Host read strobe, one cycle per access |
| busAddr | input | 1 | 0 selects the index port, 1 selects the data port |
| busWdata | input | 8 | Host write data |
| busRdata | output | 8 | Host read data, valid while busRd is high |
| evPeriodic | input | 1 | Periodic-rate event pulse |
| evAlarm | input | 1 | Alarm-match event pulse |
| evUpdate | input | 1 | Update-ended event pulse |
| uipSet | input | 1 | Calendar starts an update |
| uipClr | input | 1 | Calendar ends an update |
| resetEvt | input | 1 | Reset event that quiets enables and flags |
| ctrlA | output | 8 | Current control byte A |
| ctrlB | output | 8 | Current control byte B |
| irq | output | 1 | Active-high interrupt request |

## Verification
A wrong flag register shows at once on irq, one cycle after the offending pulse or read, and at the next host read of C, where a lost or stale flag changes the returned byte. A corrupted A or B shows on ctrlA and ctrlB in the cycle after the write and on the next read through the data port, so the bench reads back every control byte after each side-effecting access. The one-cycle race between a clearing read and a new event is driven deliberately, because a wrong priority there only shows as a missing flag on the following read.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;

  localparam int IDX_W     = 7;
  localparam int DATA_W    = 8;
  localparam int REG_COUNT = 1 << IDX_W;

  localparam logic [IDX_W-1:0] IDX_CTRL_A = 7'd10;
  localparam logic [IDX_W-1:0] IDX_CTRL_B = 7'd11;
  localparam logic [IDX_W-1:0] IDX_FLAGS  = 7'd12;
  localparam logic [IDX_W-1:0] IDX_STAT_D = 7'd13;

  localparam logic [DATA_W-1:0] RST_A    = 8'h26;
  localparam logic [DATA_W-1:0] RST_B    = 8'h02;
  localparam logic [DATA_W-1:0] VAL_D    = 8'h80;
  localparam logic [DATA_W-1:0] IDLE_RD  = 8'hFF;
  localparam logic [DATA_W-1:0] B_KEEP_ON_RESET = 8'h97;

  typedef struct packed {
    logic idxWr;
    logic wrA;
    logic wrB;
    logic wrMem;
    logic clrFlags;
  } portStrobe_t;

endpackage

// File: rtl/rtc_regport_ctrl.sv
module rtc_regport_ctrl
  import rtc_regport_pkg::*;
(
  input  logic             busWr,
  input  logic             busRd,
  input  logic             busAddr,
  input  logic [IDX_W-1:0] curIdx,
  output portStrobe_t      strb
);

  logic isCtrl;
  logic dataWr;

  always_comb begin
    isCtrl = (curIdx == IDX_CTRL_A) || (curIdx == IDX_CTRL_B) ||
             (curIdx == IDX_FLAGS)  || (curIdx == IDX_STAT_D);
    dataWr = busWr && busAddr;

    strb.idxWr    = busWr && !busAddr;
    strb.wrA      = dataWr && (curIdx == IDX_CTRL_A);
    strb.wrB      = dataWr && (curIdx == IDX_CTRL_B);
    strb.wrMem    = dataWr && !isCtrl;
    strb.clrFlags = busRd && busAddr && (curIdx == IDX_FLAGS);
  end

  always_comb begin
    a_r5_one_target: assert ($onehot0({strb.idxWr, strb.wrA, strb.wrB, strb.wrMem}))
      else $error("more than one write target in a cycle");
  end

endmodule

// File: rtl/rtc_regport_dp.sv
module rtc_regport_dp
  import rtc_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strb,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              evPeriodic,
  input  logic              evAlarm,
  input  logic              evUpdate,
  input  logic              uipSet,
  input  logic              uipClr,
  input  logic              resetEvt,
  output logic [IDX_W-1:0]  curIdx,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regB,
  output logic              irq
);

  logic [DATA_W-1:0] regC;
  logic [DATA_W-1:0] aNext, bNext, cNext;
  logic [DATA_W-1:0] selData;
  logic [DATA_W-1:0] store [REG_COUNT];
  logic [2:0]        evBits;

  // index register
  always_ff @(posedge clk) begin
    if (!rstN)           curIdx <= '0;
    else if (strb.idxWr) curIdx <= busWdata[IDX_W-1:0];
  end

  // control byte A: bit 7 is owned by the calendar handshake
  always_comb begin
    aNext = regA;
    if (strb.wrA) aNext = {regA[7], busWdata[6:0]};
    if (uipClr)                     aNext[7] = 1'b0;
    else if (uipSet && !regB[7])    aNext[7] = 1'b1;
    if (strb.wrB && busWdata[7])    aNext[7] = 1'b0;
  end

  // control byte B
  always_comb begin
    bNext = regB;
    if (strb.wrB) begin
      bNext = busWdata;
      if (busWdata[7]) bNext[4] = 1'b0;
    end
    if (resetEvt) bNext = bNext & B_KEEP_ON_RESET;
  end

  // flag byte C: clear on read, then merge events, reset event dominates
  always_comb begin
    evBits = {evPeriodic, evAlarm, evUpdate};
    cNext  = regC;
    if (strb.clrFlags) cNext = '0;
    if (|evBits) cNext = cNext | {1'b1, evBits, 4'b0000};
    if (resetEvt) cNext[7:4] = 4'b0000;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA <= RST_A;
      regB <= RST_B;
      regC <= '0;
    end else begin
      regA <= aNext;
      regB <= bNext;
      regC <= cNext;
    end
  end

  // plain storage
  always_ff @(posedge clk) begin
    if (strb.wrMem) store[curIdx] <= busWdata;
  end

  always_comb begin
    unique case (curIdx)
      IDX_CTRL_A: selData = regA;
      IDX_CTRL_B: selData = regB;
      IDX_FLAGS:  selData = regC;
      IDX_STAT_D: selData = VAL_D;
      default:    selData = store[curIdx];
    endcase
    busRdata = busAddr ? selData : IDLE_RD;
  end

  assign irq = regC[7];

  // R3: a host write to A never moves the update-in-progress bit
  a_r3_uip_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrA && !uipSet && !uipClr) |=> (regA[7] == $past(regA[7])))
    else $error("A bit 7 changed by host write");

  // R4: entering set mode clears update-in-progress and update enable
  a_r4_set_mode: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrB && busWdata[7] && !resetEvt) |=> (!regA[7] && !regB[4] && regB[7]))
    else $error("set mode side effects missing");

  // R7: a clearing read with no event leaves no flags and no request
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlags && !evPeriodic && !evAlarm && !evUpdate) |=> (regC == '0 && !irq))
    else $error("flags not cleared by read");

  // R8: an alarm racing a clearing read survives
  a_r8_event_survives: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlags && evAlarm && !resetEvt) |=> (regC[5] && regC[7] && irq))
    else $error("event lost against clearing read");

  // R9: reset event quiets enables and flags
  a_r9_reset_event: assert property (@(posedge clk) disable iff (!rstN)
    resetEvt |=> (regC[7:4] == 4'b0000 && !regB[6] && !regB[5] && !regB[3] && !irq))
    else $error("reset event did not quiet block");

  // R6: any event raises the request on the next cycle
  a_r6_event_raises: assert property (@(posedge clk) disable iff (!rstN)
    ((evPeriodic || evAlarm || evUpdate) && !resetEvt) |=> irq)
    else $error("event did not raise irq");

endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              evPeriodic,
  input  logic              evAlarm,
  input  logic              evUpdate,
  input  logic              uipSet,
  input  logic              uipClr,
  input  logic              resetEvt,
  output logic [DATA_W-1:0] ctrlA,
  output logic [DATA_W-1:0] ctrlB,
  output logic              irq
);

  portStrobe_t      strb;
  logic [IDX_W-1:0] curIdx;

  rtc_regport_ctrl u_ctrl (
    .busWr   (busWr),
    .busRd   (busRd),
    .busAddr (busAddr),
    .curIdx  (curIdx),
    .strb    (strb)
  );

  rtc_regport_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .evPeriodic (evPeriodic),
    .evAlarm    (evAlarm),
    .evUpdate   (evUpdate),
    .uipSet     (uipSet),
    .uipClr     (uipClr),
    .resetEvt   (resetEvt),
    .curIdx     (curIdx),
    .busRdata   (busRdata),
    .regA       (ctrlA),
    .regB       (ctrlB),
    .irq        (irq)
  );

endmodule

// File: tb/rtc_regport_tb.sv
module rtc_regport_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0, busRd = 1'b0, busAddr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       evPeriodic = 1'b0, evAlarm = 1'b0, evUpdate = 1'b0;
  logic       uipSet = 1'b0, uipClr = 1'b0, resetEvt = 1'b0;
  logic [7:0] ctrlA, ctrlB;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regport u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evPeriodic(evPeriodic),
    .evAlarm(evAlarm), .evUpdate(evUpdate), .uipSet(uipSet), .uipClr(uipClr),
    .resetEvt(resetEvt), .ctrlA(ctrlA), .ctrlB(ctrlB), .irq(irq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (busRd && rstN) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: unexpected read 0x%02h expected none", busRdata);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, busRdata, e);
      end
    end
  end

  task automatic busWrite(logic a, logic [7:0] d);
    @(posedge clk); #1;
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  // read with optional event pulses in the same cycle
  task automatic busReadEv(logic a, logic [7:0] exp, string tag, logic [2:0] ev);
    @(posedge clk); #1;
    expQ.push_back(exp); tagQ.push_back(tag);
    busRd = 1'b1; busAddr = a;
    {evPeriodic, evAlarm, evUpdate} = ev;
    @(posedge clk); #1;
    busRd = 1'b0;
    {evPeriodic, evAlarm, evUpdate} = 3'b000;
  endtask

  task automatic busRead(logic a, logic [7:0] exp, string tag);
    busReadEv(a, exp, tag, 3'b000);
  endtask

  task automatic readIdx(logic [6:0] idx, logic [7:0] exp, string tag);
    busWrite(1'b0, {1'b0, idx});
    busRead(1'b1, exp, tag);
  endtask

  task automatic writeIdx(logic [6:0] idx, logic [7:0] d);
    busWrite(1'b0, {1'b0, idx});
    busWrite(1'b1, d);
  endtask

  task automatic pulse(logic [2:0] ev, logic us, logic uc, logic re);
    @(posedge clk); #1;
    {evPeriodic, evAlarm, evUpdate} = ev;
    uipSet = us; uipClr = uc; resetEvt = re;
    @(posedge clk); #1;
    {evPeriodic, evAlarm, evUpdate} = 3'b000;
    uipSet = 1'b0; uipClr = 1'b0; resetEvt = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // R2 reset state
    check("R2 ctrlA", ctrlA, 8'h26);
    check("R2 ctrlB", ctrlB, 8'h02);
    check("R2 irq", {7'd0, irq}, 8'h00);
    readIdx(7'd12, 8'h00, "R2 C reset");
    readIdx(7'd13, 8'h80, "R2 D reset");
    readIdx(7'd10, 8'h26, "R2 A reset");

    // R1 index port
    busRead(1'b0, 8'hFF, "R1 even read");
    busWrite(1'b0, 8'h8E);               // bit 7 dropped -> index 14
    busWrite(1'b1, 8'h5A);
    readIdx(7'd14, 8'h5A, "R1 index bit7 dropped");

    // R10 plain storage
    writeIdx(7'd127, 8'hA5);
    writeIdx(7'd3, 8'h33);
    readIdx(7'd127, 8'hA5, "R10 idx127");
    readIdx(7'd3, 8'h33, "R10 idx3");
    readIdx(7'd14, 8'h5A, "R10 idx14 kept");

    // R11 / R3 update-in-progress bit
    pulse(3'b000, 1'b1, 1'b0, 1'b0);
    readIdx(7'd10, 8'hA6, "R11 uip set");
    busWrite(1'b1, 8'h2F);
    busRead(1'b1, 8'hAF, "R3 keep bit7 set");
    pulse(3'b000, 1'b0, 1'b1, 1'b0);
    busRead(1'b1, 8'h2F, "R11 uip clear");
    busWrite(1'b1, 8'hFF);
    busRead(1'b1, 8'h7F, "R3 keep bit7 clear");
    busWrite(1'b1, 8'h26);

    // R4 set mode side effects
    pulse(3'b000, 1'b1, 1'b0, 1'b0);
    check("R4 uip before set", ctrlA, 8'hA6);
    writeIdx(7'd11, 8'h92);
    check("R4 B with SET", ctrlB, 8'h82);
    check("R4 A bit7 cleared", ctrlA, 8'h26);
    busRead(1'b1, 8'h82, "R4 B readback");
    pulse(3'b000, 1'b1, 1'b0, 1'b0);
    check("R11 uip ignored in set mode", ctrlA, 8'h26);
    busWrite(1'b1, 8'h7E);
    busRead(1'b1, 8'h7E, "R4 B no SET");

    // R5 C and D ignore writes
    writeIdx(7'd12, 8'hFF);
    check("R5 irq after C write", {7'd0, irq}, 8'h00);
    busRead(1'b1, 8'h00, "R5 C write ignored");
    writeIdx(7'd13, 8'h00);
    busRead(1'b1, 8'h80, "R5 D write ignored");

    // R6 / R7 events and read-clear
    pulse(3'b010, 1'b0, 1'b0, 1'b0);
    check("R6 irq on alarm", {7'd0, irq}, 8'h01);
    readIdx(7'd12, 8'hA0, "R6 alarm flags");
    check("R7 irq after read", {7'd0, irq}, 8'h00);
    busRead(1'b1, 8'h00, "R7 C cleared");
    pulse(3'b101, 1'b0, 1'b0, 1'b0);
    busRead(1'b1, 8'hD0, "R6 periodic+update flags");
    busRead(1'b1, 8'h00, "R7 cleared again");

    // R8 event racing a clearing read
    pulse(3'b100, 1'b0, 1'b0, 1'b0);
    busReadEv(1'b1, 8'hC0, "R8 read during event", 3'b001);
    check("R8 irq kept", {7'd0, irq}, 8'h01);
    busRead(1'b1, 8'h90, "R8 flag survived");

    // R9 reset event
    pulse(3'b100, 1'b0, 1'b0, 1'b0);
    pulse(3'b010, 1'b0, 1'b0, 1'b1);
    check("R9 irq low", {7'd0, irq}, 8'h00);
    check("R9 B masked", ctrlB, 8'h16);
    check("R9 A kept", ctrlA, 8'h26);
    busRead(1'b1, 8'h00, "R9 C cleared");

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule